// File: doc/BRIEF.md
# Lockable Timebase Prescaler Register Unit

This block keeps an 11-bit divisor and a security-disable flag in two byte-wide registers. It divides a selectable reference clock by that divisor to produce a periodic one-cycle tick. The tick paces nonvolatile-memory timing, with a target period of roughly 35 microseconds. During reset, both registers take their contents from two shadow nonvolatile words, which arrive as input ports. This means the divisor and the lock state survive power cycles. Once the security flag is cleared, the registers freeze, the flag included. A protect output then tells the nonvolatile controller not to erase or program the shadow words.

The reference is either the bus clock, which counts every cycle of `clk`, or the crystal clock. The crystal clock appears as a one-cycle enable `xtal_en` that is synchronous to `clk`. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure. The register bus is a plain single-cycle port: a write completes in the cycle it is presented, and read data is combinational from the address.

Top module: `nvt_prescale_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the high register loads from `shadow_hi` and the low register loads from `shadow_lo`. The prescaler count clears and `tick` is low.
- R2: The high register is at byte offset 0x1A and the low register at 0x1B. The high register layout is: bit 7 is the security-disable flag, bits 6:3 always read 0 and ignore writes, and bits 2:0 are divisor bits 10:8. The low register holds divisor bits 7:0. Reads from any other offset return 0, and writes to any other offset change nothing.
- R3: A security-disable value of 1 means the unit is unlocked, and 0 means it is locked. The `sec_disable` output shows the current value.
- R4: While locked, writes to both registers are ignored, including writes to the security-disable flag.
- R5: `nv_protect` is high exactly when the unit is locked. Once high, it stays high until reset.
- R6: While `latch_busy` is 1, writes to both registers are ignored. Reads work at all times.
- R7: With divisor N ≥ 1, `tick` pulses high for one cycle once every N reference cycles.
- R8: When `ref_sel` is 1, every `clk` cycle is a reference cycle. When `ref_sel` is 0, only cycles with `xtal_en` high count.
- R9: A divisor of zero holds the count at zero and `tick` never rises.
- R10: An accepted register write clears the count and `tick`. With the bus reference selected, the first tick under divisor N is high in the Nth cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shadow_hi | input | 8 | Shadow nonvolatile word for the high register |
| shadow_lo | input | 8 | Shadow nonvolatile word for the low register |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| latch_busy | input | 1 | Latch control; 1 blocks register writes |
| ref_sel | input | 1 | Reference select: 1 = bus clock, 0 = crystal |
| xtal_en | input | 1 | One-cycle strobe per crystal clock period |
| tick | output | 1 | Timebase tick strobe |
| sec_disable | output | 1 | Current security-disable flag |
| nv_protect | output | 1 | Forbids erase/program of the shadow words |

## Verification
The bench first writes reserved bits, an unmapped offset and registers while the latch control is set. Each of these must leave the readback unchanged; a design with sloppy decode or gating would show stray bits or a changed divisor. It then sets the lock flag and writes again, including an attempt to set the flag back. A design that left the flag writable would unlock itself and drop `nv_protect`. Period checks on both reference sources and on a shadow-loaded locked divisor, a zero divisor that must stay silent, and an exact first-tick position after a divisor write would each expose an off-by-one count, a wrong clock choice, a divide-by-zero wrap, or a counter that is not reloaded.

// File: rtl/nvt_pkg.sv
package nvt_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 11;
  localparam int HI_DIV_W = DIV_W - BYTE_W;
  localparam logic [BYTE_W-1:0] OFS_HI = 8'h1A;
  localparam logic [BYTE_W-1:0] OFS_LO = 8'h1B;
  localparam int SEC_BIT = BYTE_W - 1;

  typedef struct packed {
    logic             sec_dis;
    logic [DIV_W-1:0] div;
  } cfg_t;
endpackage

// File: rtl/nvt_regfile.sv
module nvt_regfile
  import nvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] shadow_hi,
  input  logic [BYTE_W-1:0] shadow_lo,
  input  logic [BYTE_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              latch_busy,
  output logic [BYTE_W-1:0] bus_rdata,
  output cfg_t              cfg,
  output logic              wr_accept
);
  localparam int RSV_W = BYTE_W - 1 - HI_DIV_W;

  cfg_t cfg_q;
  logic wr_open, hit_hi, hit_lo;

  assign wr_open   = !latch_busy && cfg_q.sec_dis;
  assign hit_hi    = bus_wr && wr_open && (bus_addr == OFS_HI);
  assign hit_lo    = bus_wr && wr_open && (bus_addr == OFS_LO);
  assign wr_accept = hit_hi || hit_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.sec_dis <= shadow_hi[SEC_BIT];
      cfg_q.div     <= {shadow_hi[HI_DIV_W-1:0], shadow_lo};
    end else begin
      if (hit_hi) begin
        cfg_q.sec_dis                <= bus_wdata[SEC_BIT];
        cfg_q.div[DIV_W-1:BYTE_W]    <= bus_wdata[HI_DIV_W-1:0];
      end
      if (hit_lo) begin
        cfg_q.div[BYTE_W-1:0]        <= bus_wdata;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_HI:  bus_rdata = {cfg_q.sec_dis, {RSV_W{1'b0}}, cfg_q.div[DIV_W-1:BYTE_W]};
      OFS_LO:  bus_rdata = cfg_q.div[BYTE_W-1:0];
      default: bus_rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

  // R4: locked registers never change
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.sec_dis |=> $stable(cfg_q));
  // R6: latch control blocks every write
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_busy |=> $stable(cfg_q));
endmodule

// File: rtl/nvt_prescaler.sv
module nvt_prescaler #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_sel,
  input  logic             xtal_en,
  input  logic [DIV_W-1:0] div,
  input  logic             clear,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             ref_en, at_end;

  assign ref_en = ref_sel ? 1'b1 : xtal_en;
  assign at_end = (cnt_q == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear || (div == '0)) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (ref_en) begin
      cnt_q  <= at_end ? '0 : cnt_q + DIV_W'(1);
      tick_q <= at_end;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R7: count stays below a nonzero divisor
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0) |-> (cnt_q < div));
  // R8: without a crystal strobe the crystal-timed count freezes
  p_xtal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_sel && !xtal_en && !clear && div != '0) |=> ($stable(cnt_q) && !tick_q));
  // R9: zero divisor is silent
  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !tick_q);
  // R10: accepted write restarts the period
  p_clear_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && !tick_q));
endmodule

// File: rtl/nvt_prescale_regs.sv
module nvt_prescale_regs
  import nvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  shadow_hi,
  input  logic [7:0]  shadow_lo,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        latch_busy,
  input  logic        ref_sel,
  input  logic        xtal_en,
  output logic        tick,
  output logic        sec_disable,
  output logic        nv_protect
);
  cfg_t cfg;
  logic wr_accept;

  nvt_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .shadow_hi  (shadow_hi),
    .shadow_lo  (shadow_lo),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .latch_busy (latch_busy),
    .bus_rdata  (bus_rdata),
    .cfg        (cfg),
    .wr_accept  (wr_accept)
  );

  nvt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_sel (ref_sel),
    .xtal_en (xtal_en),
    .div     (cfg.div),
    .clear   (wr_accept),
    .tick    (tick)
  );

  assign sec_disable = cfg.sec_dis;
  assign nv_protect  = !cfg.sec_dis;

  // R5: protection, once on, holds until reset
  p_protect_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_protect |=> nv_protect);
endmodule

// File: tb/tb_nvt_prescale_regs.sv
module tb_nvt_prescale_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] shadow_hi = 8'h81, shadow_lo = 8'h2C;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0, latch_busy = 1'b0, ref_sel = 1'b1;
  logic xtal_en;
  logic [7:0] bus_rdata;
  logic tick, sec_disable, nv_protect;
  int n_chk = 0, n_fail = 0;
  logic [1:0] xc = 2'd0;

  always #2.5 clk = ~clk;

  always @(negedge clk) xc <= (xc == 2'd2) ? 2'd0 : xc + 2'd1;
  assign xtal_en = (xc == 2'd2);

  nvt_prescale_regs dut (.*);

  // {addr, wdata, latch, exp_hi, exp_lo}
  localparam logic [39:0] VEC [0:8] = '{
    {8'h1B, 8'h05, 8'h00, 8'h81, 8'h05},  // R2 low byte write
    {8'h1A, 8'hFA, 8'h00, 8'h82, 8'h05},  // R2 reserved bits dropped
    {8'h1B, 8'h77, 8'h01, 8'h82, 8'h05},  // R6 latch blocks low
    {8'h1A, 8'h00, 8'h01, 8'h82, 8'h05},  // R6 latch blocks high
    {8'h1C, 8'hFF, 8'h00, 8'h82, 8'h05},  // R2 unmapped offset
    {8'h1A, 8'h84, 8'h00, 8'h84, 8'h05},  // R2 high divisor bits
    {8'h1A, 8'h03, 8'h00, 8'h03, 8'h05},  // R3 lock engaged
    {8'h1A, 8'h87, 8'h00, 8'h03, 8'h05},  // R4 lock bit itself frozen
    {8'h1B, 8'h11, 8'h00, 8'h03, 8'h05}   // R4 low frozen
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] h, input logic [7:0] l);
    @(negedge clk);
    rst_n = 1'b0; shadow_hi = h; shadow_lo = l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic lt);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; latch_busy = lt; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; latch_busy = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic gap(output int g);
    int lim;
    lim = 0;
    do begin @(negedge clk); lim++; end while (!tick && lim < 5000);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick && g < 5000);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int g, bad;
    // R1: shadow contents on reset
    do_reset(8'h81, 8'h2C);
    chk("R1 tick after reset", tick, 0);
    rd(8'h1A, v); chk("R1 high from shadow", v, 8'h81);
    rd(8'h1B, v); chk("R1 low from shadow", v, 8'h2C);
    chk("R3 unlocked flag", sec_disable, 1);
    chk("R5 protect off", nv_protect, 0);
    rd(8'h10, v); chk("R2 other offset reads 0", v, 8'h00);

    foreach (VEC[i]) begin
      do_write(VEC[i][39:32], VEC[i][31:24], VEC[i][16]);
      rd(8'h1A, v); chk($sformatf("R2/R4/R6 vec%0d high", i), v, VEC[i][15:8]);
      rd(8'h1B, v); chk($sformatf("R2/R4/R6 vec%0d low", i), v, VEC[i][7:0]);
    end
    chk("R3 locked flag", sec_disable, 0);
    chk("R5 protect on", nv_protect, 1);

    // R7 / R8 periods
    do_reset(8'h80, 8'h05);
    ref_sel = 1'b1;
    gap(g); chk("R7 bus period", g, 5);
    ref_sel = 1'b0;
    gap(g); gap(g); chk("R8 crystal period", g, 15);
    ref_sel = 1'b1;

    // R10 first tick after write
    do_write(8'h1B, 8'h07, 1'b0);
    chk("R10 tick cleared by write", tick, 0);
    bad = 0;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (tick !== (i == 7)) bad++;
    end
    chk("R10 first tick at 7", bad, 0);

    // R9 zero divisor
    do_write(8'h1B, 8'h00, 1'b0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) bad++;
    end
    chk("R9 no tick at zero", bad, 0);

    // locked shadow at reset
    do_reset(8'h05, 8'h10);
    chk("R5 protect from shadow", nv_protect, 1);
    do_write(8'h1A, 8'h85, 1'b0);
    rd(8'h1A, v); chk("R4 unlock attempt ignored", v, 8'h05);
    chk("R5 protect still on", nv_protect, 1);
    gap(g); chk("R7 locked shadow period", g, 16'h510);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule